// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps a small record for every instruction in flight: a valid flag, the instruction's PC and a fault code. Each record moves one stage forward whenever the pipeline advances. A fault is not acted on in the stage that detects it. The detecting stage writes the fault into the instruction's record, and the record carries it down the pipe.

The exception is taken in the cycle in which the faulting instruction is in the memory stage and the pipeline advances. In that cycle the controller does three things:

- It kills every younger instruction: the fetch slot, decode and execute.
- It withholds the memory-write permission of the faulting instruction.
- It freezes fetch.

In the following cycle it presents the saved PC (`epc`), the cause code and a one-cycle redirect strobe with the vector address. An external interrupt is turned into a no-op that carries the interrupt cause. This no-op takes the place of the next fetched instruction, so an interrupt is ordered and taken like any other fault.

The surrounding datapath uses two permissions from this block. `mem_store_ok` gates memory writes and `wb_commit_ok` gates register writes.

Top module: `exc_pipe_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `epc` and `cause_out` are 0, `redirect` is low and `wb_commit_ok` is low.
- R2: An instruction fetched with `adv` high in cycle t reaches write-back in cycle t+4. If it has no fault, `wb_commit_ok` is high in that cycle. While `adv` is low, every stage holds its instruction.
- R3: Faults are detected in these stages: instruction TLB fault at fetch (cause 2), illegal instruction at decode (cause 3), overflow at execute (cause 4) and data TLB fault at memory (cause 5). Cause 0 means no fault. A fault pulse is recorded only for a valid instruction in the cycle in which it leaves that stage with `adv` high.
- R4: An instruction keeps only its first recorded fault. A fault reported later, in a later stage, does not replace it.
- R5: An exception is taken only in a cycle in which the faulting instruction is in the memory stage and `adv` is high. In the next cycle `redirect` is high for one cycle, `epc` holds that instruction's PC, `cause_out` holds its code and `vector_pc` holds the vector address.
- R6: In the take cycle `kill_if` is high, and `kill_id` and `kill_ex` are high for a valid decode or execute instruction. None of the killed instructions, nor the faulting one, ever raises `wb_commit_ok`.
- R7: `mem_store_ok` is low while the memory stage holds a faulting instruction, including one whose data TLB fault is reported in that same cycle.
- R8: An `irq` pulse is held pending. The next fetch slot with `fetch_valid` high, `adv` high and fetch not frozen is replaced by a no-op that carries cause 1 and the fetch PC. The interrupt takes precedence over an instruction TLB fault on the same slot.
- R9: `fetch_freeze` is high from the take cycle through the redirect cycle. Instructions offered at fetch during that time are discarded.
- R10: When several instructions in flight have faults, only the oldest one is taken. The younger ones produce no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Pipeline advances this cycle |
| fetch_valid | input | 1 | An instruction is offered at fetch |
| fetch_pc | input | 32 | PC of the offered instruction |
| irq | input | 1 | External interrupt request pulse |
| itlb_fault | input | 1 | Instruction TLB fault for the fetch slot |
| illegal_instr | input | 1 | Illegal instruction in decode |
| ovf_fault | input | 1 | Arithmetic overflow in execute |
| dtlb_fault | input | 1 | Data TLB fault in memory |
| epc | output | 32 | PC of the last taken exception |
| cause_out | output | 3 | Cause code of the last taken exception |
| redirect | output | 1 | One-cycle strobe: load `vector_pc` into the PC |
| vector_pc | output | 32 | Exception vector address |
| kill_if | output | 1 | Discard the current fetch slot |
| kill_id | output | 1 | Turn the decode instruction into a no-op |
| kill_ex | output | 1 | Turn the execute instruction into a no-op |
| fetch_freeze | output | 1 | Hold fetch until the redirect is applied |
| mem_store_ok | output | 1 | Memory stage may perform its memory write |
| wb_commit_ok | output | 1 | Write-back stage may write the register file |

## Verification
A record that falls out of step with its instruction shows up at the ports as a wrong `epc` or `cause_out` in the redirect cycle, at most four cycles after the fault was injected. A record that is not cleared on a take shows up as a commit permission or a second redirect within five cycles. A lost or overwritten fault code shows up as a missing redirect, or as a redirect with the wrong cause, when the instruction leaves the memory stage. The bench plans each instruction's fault and the cause it expects. It then compares every redirect against that plan, so a redirect that should not exist, or one with the wrong cause, is caught.

// File: rtl/exc_pipe_pkg.sv
// Shared types for the precise exception controller.
// Assumes: a 32-bit PC and four tracked stages (decode, execute, memory, write-back).
package exc_pipe_pkg;

    localparam int PC_W    = 32;
    localparam int N_STAGE = 4;          // decode, execute, memory, write-back
    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_IRQ     = 3'd1,
        CAUSE_ITLB    = 3'd2,
        CAUSE_ILLEGAL = 3'd3,
        CAUSE_OVF     = 3'd4,
        CAUSE_DTLB    = 3'd5
    } cause_e;

    // Record carried alongside each instruction
    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] pc;
        cause_e          cause;
    } slot_t;

    // Fault code recorded when an instruction leaves stage index k (0 = fetch).
    function automatic cause_e leave_code(input int k);
        case (k)
            1:       return CAUSE_ILLEGAL;
            2:       return CAUSE_OVF;
            3:       return CAUSE_DTLB;
            default: return CAUSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/exc_fetch_slot.sv
// Builds the record for the fetch slot. An interrupt request is held pending
// until a usable fetch slot appears. That slot is then replaced by a no-op that
// carries the interrupt cause.
// Assumes: fetch_pc is meaningful only when fetch_valid is high.
module exc_fetch_slot
    import exc_pipe_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            freeze,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            itlb_fault,
    input  logic            irq,
    output slot_t           if_slot
);

    logic irq_pend_q;
    logic irq_now;
    logic inject;

    assign irq_now = irq_pend_q | irq;
    assign inject  = irq_now & fetch_valid & ~freeze & adv;

    // Hold an interrupt request until it has been turned into a no-op
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_pend_q <= 1'b0;
        else if (inject) irq_pend_q <= 1'b0;
        else if (irq)    irq_pend_q <= 1'b1;
    end

    // Fetch slot record: interrupt no-op first, then instruction TLB fault
    always_comb begin
        if_slot.valid = fetch_valid & ~freeze;
        if_slot.pc    = fetch_pc;
        if (irq_now)         if_slot.cause = CAUSE_IRQ;
        else if (itlb_fault) if_slot.cause = CAUSE_ITLB;
        else                 if_slot.cause = CAUSE_NONE;
    end

endmodule

// File: rtl/exc_stage_reg.sv
// One pipeline record register. It takes the record of the stage behind it
// and, if that record has no fault yet, merges in the fault reported by the
// stage the instruction is leaving.
// Assumes: flush has priority over advance; fault applies only to a valid record.
module exc_stage_reg
    import exc_pipe_pkg::*;
#(
    parameter cause_e FLT_CODE = CAUSE_NONE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  logic  flush,
    input  slot_t d,
    input  logic  fault,
    output slot_t q
);

    cause_e merged;

    // First fault wins: a recorded code is never replaced
    always_comb begin
        if (d.cause != CAUSE_NONE)   merged = d.cause;
        else if (d.valid && fault)   merged = FLT_CODE;
        else                         merged = CAUSE_NONE;
    end

    // Record moves forward on advance, clears on flush
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q <= '0;
        end else if (adv) begin
            q.valid <= d.valid;
            q.pc    <= d.pc;
            q.cause <= merged;
        end
    end

endmodule

// File: rtl/exc_take_unit.sv
// Decides at the end of the memory stage whether to take an exception.
// On a take it saves the PC and cause and raises a one-cycle redirect.
// Assumes: the data TLB fault pulse refers to the current memory-stage record.
module exc_take_unit
    import exc_pipe_pkg::*;
#(
    parameter logic [PC_W-1:0] VECTOR = 32'h0000_0080
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  slot_t              mem_slot,
    input  logic               dtlb_fault,
    output logic               take,
    output logic               mem_store_ok,
    output logic [PC_W-1:0]    epc,
    output logic [CAUSE_W-1:0] cause_out,
    output logic               redirect,
    output logic [PC_W-1:0]    vector_pc
);

    cause_e eff_cause;

    // Effective cause at the end of the memory stage
    always_comb begin
        if (mem_slot.cause != CAUSE_NONE)    eff_cause = mem_slot.cause;
        else if (mem_slot.valid && dtlb_fault) eff_cause = CAUSE_DTLB;
        else                                  eff_cause = CAUSE_NONE;
    end

    assign take         = adv & mem_slot.valid & (eff_cause != CAUSE_NONE);
    assign mem_store_ok = mem_slot.valid & (eff_cause == CAUSE_NONE);
    assign vector_pc    = VECTOR;

    // Save the faulting PC and cause, and strobe the redirect one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc       <= '0;
            cause_out <= '0;
            redirect  <= 1'b0;
        end else begin
            redirect <= take;
            if (take) begin
                epc       <= mem_slot.pc;
                cause_out <= eff_cause;
            end
        end
    end

endmodule

// File: rtl/exc_pipe_ctrl.sv
// Top of the precise exception controller. Chains the fetch record into four
// stage records, takes exceptions at the end of memory, flushes younger work
// and freezes fetch until the vector redirect has been applied.
// Assumes: one instruction per stage and one global advance signal.
module exc_pipe_ctrl
    import exc_pipe_pkg::*;
#(
    parameter logic [31:0] VECTOR = 32'h0000_0080
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    input  logic        irq,
    input  logic        itlb_fault,
    input  logic        illegal_instr,
    input  logic        ovf_fault,
    input  logic        dtlb_fault,
    output logic [31:0] epc,
    output logic [2:0]  cause_out,
    output logic        redirect,
    output logic [31:0] vector_pc,
    output logic        kill_if,
    output logic        kill_id,
    output logic        kill_ex,
    output logic        fetch_freeze,
    output logic        mem_store_ok,
    output logic        wb_commit_ok
);

    localparam int ID_IX  = 1;
    localparam int EX_IX  = 2;
    localparam int MEM_IX = 3;
    localparam int WB_IX  = N_STAGE;

    slot_t              chain [0:N_STAGE];   // 0 = fetch, 1..4 = decode..write-back
    logic [N_STAGE-1:0] leave_fault;
    logic               take;

    assign leave_fault = {dtlb_fault, ovf_fault, illegal_instr, 1'b0};
    assign fetch_freeze = take | redirect;

    exc_fetch_slot u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .freeze      (fetch_freeze),
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .itlb_fault  (itlb_fault),
        .irq         (irq),
        .if_slot     (chain[0])
    );

    for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
        exc_stage_reg #(.FLT_CODE(leave_code(k))) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .flush (take),
            .d     (chain[k]),
            .fault (leave_fault[k]),
            .q     (chain[k+1])
        );
    end

    exc_take_unit #(.VECTOR(VECTOR)) u_take (
        .clk          (clk),
        .rst_n        (rst_n),
        .adv          (adv),
        .mem_slot     (chain[MEM_IX]),
        .dtlb_fault   (dtlb_fault),
        .take         (take),
        .mem_store_ok (mem_store_ok),
        .epc          (epc),
        .cause_out    (cause_out),
        .redirect     (redirect),
        .vector_pc    (vector_pc)
    );

    assign kill_if      = take;
    assign kill_id      = take & chain[ID_IX].valid;
    assign kill_ex      = take & chain[EX_IX].valid;
    assign wb_commit_ok = chain[WB_IX].valid;

endmodule

// File: rtl/exc_pipe_ctrl_chk.sv
// Port-level temporal checks for exc_pipe_ctrl, attached with bind.
module exc_pipe_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adv,
    input logic       kill_if,
    input logic       redirect,
    input logic       fetch_freeze,
    input logic       mem_store_ok,
    input logic       wb_commit_ok,
    input logic [2:0] cause_out
);

    // R5
    take_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_if |=> redirect);

    // R5
    redirect_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (cause_out >= 3'd1 && cause_out <= 3'd5));

    // R5
    stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |-> !kill_if);

    // R9
    freeze_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_if || redirect) |-> fetch_freeze);

    // R7
    take_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_if |-> !mem_store_ok);

    // R6
    redirect_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !wb_commit_ok);

    // R10
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !kill_if);

endmodule

bind exc_pipe_ctrl exc_pipe_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .adv          (adv),
    .kill_if      (kill_if),
    .redirect     (redirect),
    .fetch_freeze (fetch_freeze),
    .mem_store_ok (mem_store_ok),
    .wb_commit_ok (wb_commit_ok),
    .cause_out    (cause_out)
);

// File: tb/exc_pipe_ctrl_test.sv
// Scoreboard bench: fault scenarios push the expected redirect into a queue,
// and a monitor pops and compares each redirect the design produces.
module exc_pipe_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        adv, fetch_valid, irq;
    logic [31:0] fetch_pc;
    logic        itlb_fault, illegal_instr, ovf_fault, dtlb_fault;
    logic [31:0] epc, vector_pc;
    logic [2:0]  cause_out;
    logic        redirect, kill_if, kill_id, kill_ex;
    logic        fetch_freeze, mem_store_ok, wb_commit_ok;

    localparam logic [31:0] VEC = 32'h0000_0080;

    always #2 clk = ~clk;   // 250 MHz

    exc_pipe_ctrl #(.VECTOR(VEC)) uut (.*);

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;

    logic [34:0] exp_q [$];   // {pc, cause}
    string       tag_q [$];

    // planned fault bits per instruction: [0] itlb, [1] illegal, [2] overflow, [3] data tlb
    logic [3:0] plan_id = '0, plan_ex = '0, plan_mem = '0, cur_f = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at the falling edge
    task automatic put(input logic fv, input logic [31:0] pc, input logic [3:0] f,
                       input logic ir, input logic a);
        @(negedge clk);
        fetch_valid   = fv;
        fetch_pc      = pc;
        itlb_fault    = fv & f[0];
        illegal_instr = plan_id[1];
        ovf_fault     = plan_ex[2];
        dtlb_fault    = plan_mem[3];
        irq           = ir;
        adv           = a;
        cur_f         = fv ? f : 4'b0;
        #1;
    endtask

    // Let the rising edge pass and move the fault plan with the pipeline
    task automatic tick();
        @(posedge clk);
        if (adv) begin
            plan_mem = plan_ex;
            plan_ex  = plan_id;
            plan_id  = cur_f;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 6; i++) begin
            put(1'b0, 32'h0, 4'b0, 1'b0, 1'b1);
            tick();
        end
    endtask

    // Issue an instruction with faults f (or an interrupt) and a younger one
    // with faults fy, optionally stall while it sits in memory, and check
    // the take, the redirect and the commit behaviour around it.
    task automatic fault_case(input string req, input logic [31:0] pc, input logic [3:0] f,
                              input logic ir, input logic [3:0] fy, input int stall,
                              input logic [2:0] exp_cause);
        exp_q.push_back({pc, exp_cause});
        tag_q.push_back(req);
        put(1'b1, pc, f, ir, 1'b1);          tick();
        put(1'b1, pc + 4, fy, 1'b0, 1'b1);   tick();
        put(1'b1, pc + 8, 4'b0, 1'b0, 1'b1); tick();
        for (int s = 0; s < stall; s++) begin
            put(1'b1, pc + 12, 4'b0, 1'b0, 1'b0);
            check("R5 no take while stalled", {31'b0, kill_if}, 32'd0);
            tick();
            check("R5 no redirect while stalled", {31'b0, redirect}, 32'd0);
        end
        put(1'b1, pc + 12, 4'b0, 1'b0, 1'b1);
        check("R6 kill_if in take cycle", {31'b0, kill_if}, 32'd1);
        check("R6 kill_id in take cycle", {31'b0, kill_id}, 32'd1);
        check("R6 kill_ex in take cycle", {31'b0, kill_ex}, 32'd1);
        check("R7 store blocked for faulting instr", {31'b0, mem_store_ok}, 32'd0);
        check("R9 freeze in take cycle", {31'b0, fetch_freeze}, 32'd1);
        tick();
        // offered during freeze with an instruction TLB fault: must vanish
        put(1'b1, pc + 16, 4'b0001, 1'b0, 1'b1);
        check("R9 freeze in redirect cycle", {31'b0, fetch_freeze}, 32'd1);
        check("R6 no commit after take", {31'b0, wb_commit_ok}, 32'd0);
        tick();
        for (int i = 0; i < 4; i++) begin
            put(1'b1, pc + 32 + 4 * i, 4'b0, 1'b0, 1'b1);
            check("R6 flushed instrs never commit", {31'b0, wb_commit_ok}, 32'd0);
            tick();
        end
        put(1'b0, 32'h0, 4'b0, 1'b0, 1'b1);
        check("R2 fetch resumes after redirect", {31'b0, wb_commit_ok}, 32'd1);
        tick();
        drain();
    endtask

    // Monitor: every redirect must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n === 1'b1 && redirect === 1'b1) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R10 unexpected redirect actual epc=%h cause=%0d expected none",
                         epc, cause_out);
            end else begin
                automatic logic [34:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check({t, " epc"}, epc, e[34:3]);
                check({t, " cause"}, {29'b0, cause_out}, {29'b0, e[2:0]});
                check("R5 vector address", vector_pc, VEC);
            end
        end
    end

    initial begin
        rst_n = 1'b0; adv = 1'b0; fetch_valid = 1'b0; fetch_pc = '0; irq = 1'b0;
        itlb_fault = 1'b0; illegal_instr = 1'b0; ovf_fault = 1'b0; dtlb_fault = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 epc reset", epc, 32'h0);
        check("R1 cause reset", {29'b0, cause_out}, 32'h0);
        check("R1 redirect reset", {31'b0, redirect}, 32'h0);
        check("R1 no commit at reset", {31'b0, wb_commit_ok}, 32'h0);
        rst_n = 1'b1;

        // R2: clean stream, commit four cycles after fetch, then hold
        for (int i = 0; i < 6; i++) begin
            put(1'b1, 32'h100 + 4 * i, 4'b0, 1'b0, 1'b1);
            if (i >= 4) check("R2 commit four cycles after fetch", {31'b0, wb_commit_ok}, 32'd1);
            if (i < 4)  check("R2 nothing in write-back yet", {31'b0, wb_commit_ok}, 32'd0);
            if (i >= 3) check("R7 clean store allowed", {31'b0, mem_store_ok}, 32'd1);
            tick();
        end
        for (int i = 0; i < 2; i++) begin
            put(1'b0, 32'h0, 4'b0, 1'b0, 1'b0);
            check("R2 hold keeps write-back", {31'b0, wb_commit_ok}, 32'd1);
            tick();
        end
        drain();

        // R3: each fault source and its code
        fault_case("R3 overflow",      32'h200, 4'b0100, 1'b0, 4'b0, 0, 3'd4);
        fault_case("R3 illegal",       32'h300, 4'b0010, 1'b0, 4'b0, 0, 3'd3);
        fault_case("R3 itlb",          32'h400, 4'b0001, 1'b0, 4'b0, 0, 3'd2);
        fault_case("R3 dtlb",          32'h500, 4'b1000, 1'b0, 4'b0, 0, 3'd5);
        // R4: first fault kept
        fault_case("R4 itlb then ovf", 32'h600, 4'b0101, 1'b0, 4'b0, 0, 3'd2);
        fault_case("R4 ill then dtlb", 32'h700, 4'b1010, 1'b0, 4'b0, 0, 3'd3);
        // R8: interrupt on the fetch slot beats itlb
        fault_case("R8 irq no-op",     32'h800, 4'b0001, 1'b1, 4'b0, 0, 3'd1);
        // R8: pending interrupt waits for a fetch slot
        put(1'b0, 32'h0, 4'b0, 1'b1, 1'b1); tick();
        put(1'b0, 32'h0, 4'b0, 1'b0, 1'b1); tick();
        fault_case("R8 latched irq",   32'h900, 4'b0000, 1'b0, 4'b0, 0, 3'd1);
        // R10: older dtlb beats younger illegal
        fault_case("R10 oldest first", 32'hA00, 4'b1000, 1'b0, 4'b0010, 0, 3'd5);
        // R5: stalled in memory, taken only when advancing
        fault_case("R5 stall then take", 32'hB00, 4'b0100, 1'b0, 4'b0, 2, 3'd4);

        check("R5 all expected redirects seen", exp_q.size(), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule